// File: doc/BRIEF.md
# Comparator-Gated Interval Timer

This block is a 16-bit event counter that advances on the rising edges of a slow, free-running timer clock, after a power-of-two prescaler. Its counting can be gated by a level: either an external gate pin or the digital output of a second comparator. The comparator path can be retimed to the falling edge of the prescaled timer clock. The gate level is then frozen half a period before each increment, so a comparator transition can never land on the same edge as a count.

A small 8-bit control/status register holds the gate-source choice, the retiming enable and two reference-select bits. The two reference-select bits leave the block as plain outputs. The register also returns both comparator levels side by side, so software sees them as one coherent snapshot.

The timer clock, both comparator bits and the gate pin are asynchronous to the system clock. Each is brought in through a two-flop synchronizer. Timer-clock edges become single-cycle enables in the system clock domain. A wrap of the counter raises a one-cycle overflow pulse.

Top module: `gtmr_top`

## Requirements
- R1: After a synchronous active-low reset, the count reads 0. The overflow output is low. With both comparators low, the register reads 0x02: only the gate-source bit (bit 1) is set.
- R2: A register write loads bits 5 (comparator-1 reference select), 4 (comparator-2 reference select), 1 (gate source) and 0 (retiming enable) from the write data. Bits 7 and 6 ignore written values. Bits 3 and 2 always read 0. Outputs ref1_sel_o and ref2_sel_o follow bits 5 and 4.
- R3: Bit 7 mirrors comparator 1 and bit 6 mirrors comparator 2. Both are taken from the same synchronizer stage, two system clocks after the input changes. A simultaneous change of both inputs is therefore never seen split across two reads.
- R4: With the timer on and gating disabled, the count rises by exactly one per prescaled rising timer-clock edge.
- R5: With tmr_on_i low, the count holds whatever the timer clock, gate pin or comparators do.
- R6: pre_sel_i values 0, 1, 2 and 3 divide the timer clock by 1, 2, 4 and 8. Sixteen raw rising edges give 16, 8, 4 and 2 increments.
- R7: With gating enabled and bit 1 = 1, the count advances only while the gate pin is high. A register write that lands in the same system cycle as an increment takes effect only after that increment.
- R8: With gating enabled, bit 1 = 0 and bit 0 = 0, the count advances only while comparator 2 is high, and that level is taken unlatched.
- R9: With bit 0 = 1, comparator 2 is captured only on falling edges of the prescaled timer clock. A change made while the timer clock is low does not affect the next increment.
- R10: The count wraps from 0xFFFF to 0x0000, and overflow is high for exactly one system-clock cycle at that wrap.

Two further properties are checked by assertions. A prescaled rising edge and a prescaled falling edge never fall in the same cycle. The retiming latch changes only on a prescaled falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_clk_i | input | 1 | Asynchronous timer clock source |
| cmp1_i | input | 1 | Comparator 1 digital output, asynchronous |
| cmp2_i | input | 1 | Comparator 2 digital output, asynchronous |
| gate_pin_i | input | 1 | External gate level, active high, asynchronous |
| tmr_on_i | input | 1 | Timer enable |
| gate_en_i | input | 1 | Gating enable |
| pre_sel_i | input | 2 | Prescale select: 0=1, 1=2, 2=4, 3=8 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational, side-effect free) |
| ref1_sel_o | output | 1 | Comparator-1 reference select (bit 5) |
| ref2_sel_o | output | 1 | Comparator-2 reference select (bit 4) |
| count_o | output | 16 | Timer count |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
A register write and a counter increment can land on the same system clock edge. The case that matters is a write that changes the gate source while an increment is being decided. The bench places the write strobe on the edge where the synchronized timer-clock rise is consumed. The old source (gate pin low) blocks that count. The new source (comparator 2 high) may only admit the following one, so the count must be unchanged after the first pulse and one higher after the second. Separately, changing both comparators together and reading on consecutive cycles shows that both mirror bits switch on the same cycle.

// File: rtl/gtmr_pkg.sv
// Package: shared constants for the comparator-gated timer.
// Assumes: register bit positions below are decoded by software, so they are fixed.
package gtmr_pkg;
    localparam int REG_W       = 8;
    localparam int BIT_MIR1    = 7;
    localparam int BIT_MIR2    = 6;
    localparam int BIT_REF1    = 5;
    localparam int BIT_REF2    = 4;
    localparam int BIT_GSRC    = 1;
    localparam int BIT_RETIME  = 0;
    localparam logic GSRC_RST  = 1'b1;

    // Control fields held by the register file
    typedef struct packed {
        logic ref1;
        logic ref2;
        logic gsrc;    // 1: gate pin, 0: comparator 2
        logic retime;  // 1: comparator 2 latched on prescaled falling edge
    } gtmr_ctrl_t;
endpackage

// File: rtl/gtmr_sync.sv
// Module: gtmr_sync
// Brings one asynchronous bit into the system clock domain through a chain of
// flops and reports its rising and falling edges as single-cycle enables.
// Assumes: the input stays at each level for at least one system clock.
module gtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the asynchronous bit through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~last_q;
    assign fall_o  = ~chain_q[STAGES-1] & last_q;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o)); // R4
endmodule

// File: rtl/gtmr_prescale.sv
// Module: gtmr_prescale
// Divides the timer clock by 2**sel and produces rising- and falling-edge
// enables of the divided clock. For sel=0 the raw edges pass straight through.
// For larger ratios both divided edges fall on raw rising edges, at opposite
// points of the divider cycle.
// Assumes: sel_i is quasi-static; a change may shorten one divided period.
module gtmr_prescale #(
    parameter int SEL_W = 2,
    localparam int DIV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_rise_i,
    input  logic             tick_fall_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             pre_rise_o,
    output logic             pre_fall_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [DIV_W-1:0] half;

    // Count raw rising timer-clock edges
    always_ff @(posedge clk) begin
        if (!rst_n)           div_q <= '0;
        else if (tick_rise_i) div_q <= div_q + 1'b1;
    end

    // Derive divided edge enables from the raw edge and the divider phase
    always_comb begin
        mask = DIV_W'((1 << sel_i) - 1);
        half = mask >> 1;
        if (sel_i == '0) begin
            pre_rise_o = tick_rise_i;
            pre_fall_o = tick_fall_i;
        end else begin
            pre_rise_o = tick_rise_i && ((div_q & mask) == mask);
            pre_fall_o = tick_rise_i && ((div_q & mask) == half);
        end
    end

    AST_PRE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_rise_o, pre_fall_o})); // R9
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_rise_i |=> $stable(div_q)); // R6
endmodule

// File: rtl/gtmr_gate.sv
// Module: gtmr_gate
// Picks the gate level for the counter. Comparator 2 is either used at its
// synchronized level or latched on each prescaled falling edge, so its value
// is settled half a period before the next increment.
// Assumes: all inputs are already in the system clock domain.
module gtmr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp2_lvl_i,
    input  logic pin_lvl_i,
    input  logic pre_fall_i,
    input  logic retime_i,
    input  logic gsrc_i,
    output logic gate_lvl_o
);
    logic cmp2_latch_q;
    logic cmp2_eff;

    // Capture comparator 2 on each prescaled falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)          cmp2_latch_q <= 1'b0;
        else if (pre_fall_i) cmp2_latch_q <= cmp2_lvl_i;
    end

    // Choose latched or direct comparator level, then the gate source
    always_comb begin
        cmp2_eff   = retime_i ? cmp2_latch_q : cmp2_lvl_i;
        gate_lvl_o = gsrc_i ? pin_lvl_i : cmp2_eff;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_fall_i |=> $stable(cmp2_latch_q)); // R9
endmodule

// File: rtl/gtmr_regs.sv
// Module: gtmr_regs
// Control/status register: four writable control bits plus two live
// comparator mirrors taken from one synchronizer stage. Reads have no strobe
// and so cannot disturb any state.
// Assumes: writes are single-cycle strobes in the system domain.
module gtmr_regs
    import gtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             mir1_i,
    input  logic             mir2_i,
    output logic [REG_W-1:0] rdata_o,
    output gtmr_ctrl_t       ctrl_o
);
    gtmr_ctrl_t ctrl_q;

    // Load the writable control fields on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.ref1   <= 1'b0;
            ctrl_q.ref2   <= 1'b0;
            ctrl_q.gsrc   <= GSRC_RST;
            ctrl_q.retime <= 1'b0;
        end else if (wr_i) begin
            ctrl_q.ref1   <= wdata_i[BIT_REF1];
            ctrl_q.ref2   <= wdata_i[BIT_REF2];
            ctrl_q.gsrc   <= wdata_i[BIT_GSRC];
            ctrl_q.retime <= wdata_i[BIT_RETIME];
        end
    end

    // Assemble the read word; unused bits read zero
    always_comb begin
        rdata_o             = '0;
        rdata_o[BIT_MIR1]   = mir1_i;
        rdata_o[BIT_MIR2]   = mir2_i;
        rdata_o[BIT_REF1]   = ctrl_q.ref1;
        rdata_o[BIT_REF2]   = ctrl_q.ref2;
        rdata_o[BIT_GSRC]   = ctrl_q.gsrc;
        rdata_o[BIT_RETIME] = ctrl_q.retime;
    end

    assign ctrl_o = ctrl_q;

    AST_WR_GSRC: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ctrl_q.gsrc == $past(wdata_i[BIT_GSRC])); // R2
    AST_NOWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/gtmr_counter.sv
// Module: gtmr_counter
// Up-counter that advances by one on each qualified prescaled rising edge,
// wraps to zero and pulses overflow for one cycle on the wrap.
// Assumes: inc_i is a single-cycle enable.
module gtmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Advance the count on each enable
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    // Flag the wrap from all-ones to zero for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= inc_i && (cnt_q == CNT_MAX);
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q)); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> cnt_q == $past(cnt_q) + 1'b1); // R4
    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q); // R10
    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> cnt_q == '0); // R10
endmodule

// File: rtl/gtmr_top.sv
// Module: gtmr_top
// Comparator-gated interval timer: synchronizes the asynchronous inputs,
// prescales the timer clock, selects and optionally retimes the gate, and
// counts qualified prescaled rising edges.
// Assumes: tmr_on_i, gate_en_i and pre_sel_i are driven in the system domain.
module gtmr_top
    import gtmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_clk_i,
    input  logic             cmp1_i,
    input  logic             cmp2_i,
    input  logic             gate_pin_i,
    input  logic             tmr_on_i,
    input  logic             gate_en_i,
    input  logic [SEL_W-1:0] pre_sel_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             ref1_sel_o,
    output logic             ref2_sel_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam int N_ASYNC = 4;
    localparam int IX_TCLK = 0;
    localparam int IX_CMP1 = 1;
    localparam int IX_CMP2 = 2;
    localparam int IX_PIN  = 3;

    logic [N_ASYNC-1:0] async_vec;
    logic [N_ASYNC-1:0] lvl_vec;
    logic [N_ASYNC-1:0] rise_vec;
    logic [N_ASYNC-1:0] fall_vec;
    logic               pre_rise;
    logic               pre_fall;
    logic               gate_lvl;
    logic               inc;
    gtmr_ctrl_t         ctrl;

    assign async_vec = {gate_pin_i, cmp2_i, cmp1_i, tmr_clk_i};

    // One synchronizer per asynchronous input
    for (genvar gi = 0; gi < N_ASYNC; gi++) begin : g_sync
        gtmr_sync #(.STAGES(STAGES)) sync_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (async_vec[gi]),
            .level_o (lvl_vec[gi]),
            .rise_o  (rise_vec[gi]),
            .fall_o  (fall_vec[gi])
        );
    end

    gtmr_prescale #(.SEL_W(SEL_W)) pre_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_rise_i (rise_vec[IX_TCLK]),
        .tick_fall_i (fall_vec[IX_TCLK]),
        .sel_i       (pre_sel_i),
        .pre_rise_o  (pre_rise),
        .pre_fall_o  (pre_fall)
    );

    gtmr_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .mir1_i  (lvl_vec[IX_CMP1]),
        .mir2_i  (lvl_vec[IX_CMP2]),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl)
    );

    gtmr_gate gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp2_lvl_i (lvl_vec[IX_CMP2]),
        .pin_lvl_i  (lvl_vec[IX_PIN]),
        .pre_fall_i (pre_fall),
        .retime_i   (ctrl.retime),
        .gsrc_i     (ctrl.gsrc),
        .gate_lvl_o (gate_lvl)
    );

    // Qualify each prescaled rising edge with timer enable and gate
    always_comb begin
        inc = pre_rise && tmr_on_i && (!gate_en_i || gate_lvl);
    end

    gtmr_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (inc),
        .cnt_o (count_o),
        .ovf_o (ovf_o)
    );

    assign ref1_sel_o = ctrl.ref1;
    assign ref2_sel_o = ctrl.ref2;

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_on_i |=> $stable(count_o)); // R5
    AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> ref1_sel_o == $past(reg_wdata_i[BIT_REF1])); // R2
endmodule

// File: tb/gtmr_top_tb_top.sv
// Directed bench for gtmr_top: one task per scenario, each checking its results.
module gtmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_clk_i = 1'b0;
    logic        cmp1_i = 1'b0;
    logic        cmp2_i = 1'b0;
    logic        gate_pin_i = 1'b0;
    logic        tmr_on_i = 1'b0;
    logic        gate_en_i = 1'b0;
    logic [1:0]  pre_sel_i = 2'd0;
    logic        reg_wr_i = 1'b0;
    logic [7:0]  reg_wdata_i = 8'h00;
    logic [7:0]  reg_rdata_o;
    logic        ref1_sel_o;
    logic        ref2_sel_o;
    logic [15:0] count_o;
    logic        ovf_o;

    int n_run = 0;
    int n_fail = 0;
    int ovf_cycles = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gtmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_clk_i(tmr_clk_i), .cmp1_i(cmp1_i),
        .cmp2_i(cmp2_i), .gate_pin_i(gate_pin_i), .tmr_on_i(tmr_on_i),
        .gate_en_i(gate_en_i), .pre_sel_i(pre_sel_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .ref1_sel_o(ref1_sel_o), .ref2_sel_o(ref2_sel_o),
        .count_o(count_o), .ovf_o(ovf_o)
    );

    // Count overflow-high cycles and run a watchdog
    always @(negedge clk) begin
        cyc++;
        if (rst_n && ovf_o) ovf_cycles++;
        if (cyc > 195000 && !done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<195000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = d;
        @(negedge clk); reg_wr_i = 1'b0;
    endtask

    task automatic tclk_rise();
        @(negedge clk); tmr_clk_i = 1'b1; idle(4);
    endtask

    task automatic tclk_fall();
        @(negedge clk); tmr_clk_i = 1'b0; idle(4);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin tclk_rise(); tclk_fall(); end
    endtask

    task automatic t_reset();
        idle(2);
        check(count_o == 16'h0, "R1 count", count_o, 0);
        check(reg_rdata_o == 8'h02, "R1 reg", reg_rdata_o, 8'h02);
        check(ovf_o == 1'b0, "R1 ovf", ovf_o, 0);
    endtask

    task automatic t_regs();
        wr_reg(8'hFF);
        check(reg_rdata_o == 8'h33, "R2 write all ones", reg_rdata_o, 8'h33);
        check(ref1_sel_o && ref2_sel_o, "R2 ref outs", {ref1_sel_o, ref2_sel_o}, 3);
        wr_reg(8'h12);
        check(reg_rdata_o == 8'h12, "R2 write 0x12", reg_rdata_o, 8'h12);
        check(!ref1_sel_o && ref2_sel_o, "R2 ref outs 2", {ref1_sel_o, ref2_sel_o}, 1);
        wr_reg(8'h02);
    endtask

    task automatic t_mirror();
        @(negedge clk); cmp1_i = 1'b1; cmp2_i = 1'b0; idle(4);
        check(reg_rdata_o[7:6] == 2'b10, "R3 mirrors 10", reg_rdata_o[7:6], 2);
        @(negedge clk); cmp1_i = 1'b0; cmp2_i = 1'b1;
        @(negedge clk);
        check(reg_rdata_o[7:6] == 2'b10, "R3 no skew old", reg_rdata_o[7:6], 2);
        @(negedge clk);
        check(reg_rdata_o[7:6] == 2'b01, "R3 no skew new", reg_rdata_o[7:6], 1);
        @(negedge clk); cmp1_i = 1'b0; cmp2_i = 1'b0; idle(4);
    endtask

    task automatic t_free_count();
        int c0;
        tmr_on_i = 1'b1; gate_en_i = 1'b0; pre_sel_i = 2'd0;
        c0 = count_o; pulses(5);
        check(count_o == 16'(c0 + 5), "R4 five pulses", count_o, c0 + 5);
    endtask

    task automatic t_off();
        int c0;
        tmr_on_i = 1'b0; gate_pin_i = 1'b1; cmp2_i = 1'b1;
        c0 = count_o; pulses(4);
        check(count_o == 16'(c0), "R5 timer off", count_o, c0);
        tmr_on_i = 1'b1; gate_pin_i = 1'b0; cmp2_i = 1'b0; idle(4);
    endtask

    task automatic t_prescale();
        int c0;
        gate_en_i = 1'b0;
        for (int s = 0; s < 4; s++) begin
            pre_sel_i = 2'(s);
            c0 = count_o; pulses(16);
            check(count_o == 16'(c0 + (16 >> s)), "R6 ratio", count_o - c0, 16 >> s);
        end
        pre_sel_i = 2'd0;
    endtask

    task automatic t_pin_gate();
        int c0;
        gate_en_i = 1'b1; wr_reg(8'h02);
        gate_pin_i = 1'b0; idle(4);
        c0 = count_o; pulses(3);
        check(count_o == 16'(c0), "R7 pin low blocks", count_o, c0);
        gate_pin_i = 1'b1; idle(4);
        c0 = count_o; pulses(3);
        check(count_o == 16'(c0 + 3), "R7 pin high counts", count_o, c0 + 3);
        // Same-cycle: source switch lands on the increment edge
        gate_pin_i = 1'b0; cmp2_i = 1'b1; idle(4);
        c0 = count_o;
        @(negedge clk); tmr_clk_i = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = 8'h00;
        @(negedge clk); reg_wr_i = 1'b0; idle(3);
        tclk_fall();
        check(count_o == 16'(c0), "R7 write same cycle uses old gate", count_o, c0);
        pulses(1);
        check(count_o == 16'(c0 + 1), "R7 new gate after write", count_o, c0 + 1);
    endtask

    task automatic t_cmp_gate();
        int c0;
        wr_reg(8'h00); cmp2_i = 1'b0; idle(4);
        c0 = count_o; pulses(2);
        check(count_o == 16'(c0), "R8 cmp2 low blocks", count_o, c0);
        cmp2_i = 1'b1; idle(4);
        c0 = count_o; pulses(2);
        check(count_o == 16'(c0 + 2), "R8 cmp2 high counts", count_o, c0 + 2);
    endtask

    task automatic t_retime();
        int c0;
        cmp2_i = 1'b0; idle(4);
        wr_reg(8'h01);
        pulses(1);                 // falling edge latches 0
        c0 = count_o;
        cmp2_i = 1'b1; idle(4);    // change while timer clock low
        tclk_rise();
        check(count_o == 16'(c0), "R9 latched low blocks", count_o, c0);
        tclk_fall();               // latches 1
        tclk_rise();
        check(count_o == 16'(c0 + 1), "R9 latched high counts", count_o, c0 + 1);
        tclk_fall();
        wr_reg(8'h00); cmp2_i = 1'b0; idle(4);
        c0 = count_o;
        cmp2_i = 1'b1; idle(4);
        tclk_rise(); tclk_fall();
        check(count_o == 16'(c0 + 1), "R9 unlatched follows at once", count_o, c0 + 1);
    endtask

    task automatic t_wrap();
        int left;
        gate_en_i = 1'b0; pre_sel_i = 2'd0;
        left = 65535 - int'(count_o);
        for (int i = 0; i < left; i++) begin
            @(negedge clk); tmr_clk_i = 1'b1;
            @(negedge clk); tmr_clk_i = 1'b0;
        end
        idle(4);
        check(count_o == 16'hFFFF, "R10 reach max", count_o, 16'hFFFF);
        check(ovf_cycles == 0, "R10 no early ovf", ovf_cycles, 0);
        pulses(1);
        check(count_o == 16'h0, "R10 wrap to zero", count_o, 0);
        check(ovf_cycles == 1, "R10 one-cycle ovf", ovf_cycles, 1);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_mirror();
        t_free_count();
        t_off();
        t_prescale();
        t_pin_gate();
        t_cmp_gate();
        t_retime();
        t_wrap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule